// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block sits between an interrupt source layer and a single processor. It keeps one 32-bit presentation word, which holds the processor's current priority in the upper byte and the number of the source now pending in the lower 24 bits. Beside that word it keeps two bytes: the priority of the pending source, and a request priority for inter-processor interrupts (IPI). Numerically lower priorities are more favored, and the value 0xFF means "none". The source layer offers interrupts. The controller either takes an offer, possibly displacing the source that was pending, or hands the offer straight back. It drives one interrupt line to the processor.

The processor works through a command port with a valid/ready handshake. It can change its current priority, write the IPI priority, accept the pending interrupt, signal end-of-interrupt (EOI) and poll. The controller talks back to the source layer with one-cycle pulses: reject (with the source number), EOI (with the source number) and a request to resend held-back interrupts. IPIs use the same pending field as device sources, under the fixed source number 2.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After synchronous reset, the presentation word is 0x00000000, the pending priority and the IPI priority are 0xFF, the interrupt line is low, and no pulse is active.
- R2: An offer whose priority is numerically greater than or equal to the current priority is handed back. `rej_valid` pulses with that source number in the cycle after the offer, and the pending state and the interrupt line stay unchanged.
- R3: An offer is also handed back when a source is pending whose priority is equal to or more favored than the offered one.
- R4: Any other offer is latched as source and pending priority, and the interrupt line goes high in the cycle after the offer. If a source was pending, that displaced source is rejected in the same cycle.
- R5: ACCEPT (op 2) returns the full presentation word as it stood before the command and lowers the line. It then loads the pending priority into bits 31:24, clears bits 23:0, and sets the pending priority to 0xFF.
- R6: EOI (op 3) copies `cmd_data[31:24]` into the current priority and pulses `eoi_valid` with `cmd_data[23:0]`. If nothing is pending afterwards, it runs the resend procedure.
- R7: SET_CPPR (op 0, value in `cmd_data[7:0]`) with a more favored value clears a pending source whose priority is not more favored than the new value. It sets the pending priority to 0xFF, lowers the line and rejects that source. A pending source that is more favored than the new value stays pending.
- R8: SET_CPPR with an equal or less favored value, while nothing is pending, runs the resend procedure. The procedure first runs the IPI check if the IPI priority is more favored than the current priority, and in every case pulses `resend_req`.
- R9: SET_IPI (op 1, value in `cmd_data[7:0]`) stores the IPI priority and runs the IPI check when that value is more favored than the current priority. The check rejects any pending source, loads source number 2 with the IPI priority as its pending priority, and raises the line.
- R10: The IPI check changes nothing when the pending source's priority is equal to or more favored than the IPI priority.
- R11: POLL (op 4) returns the presentation word on `rsp_word` and the IPI priority on `rsp_ipi`, and changes no state.
- R12: `cmd_ready` is low whenever `offer_valid` is high, so an offer always takes the cycle. ACCEPT and POLL set `rsp_valid` for exactly one cycle, the cycle after the command is taken. All pulses to the source layer appear in the cycle after the event that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | Source layer presents an interrupt this cycle |
| offer_src | input | SRC_W | Offered source number (nonzero) |
| offer_prio | input | PRIO_W | Offered priority |
| cmd_valid | input | 1 | Processor command present |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_op | input | 3 | Command code: 0 SET_CPPR, 1 SET_IPI, 2 ACCEPT, 3 EOI, 4 POLL |
| cmd_data | input | PRIO_W+SRC_W | Command operand |
| rsp_valid | output | 1 | Response word valid (ACCEPT, POLL) |
| rsp_word | output | PRIO_W+SRC_W | Presentation word returned |
| rsp_ipi | output | PRIO_W | IPI priority returned by POLL |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | SRC_W | Rejected source number |
| eoi_valid | output | 1 | EOI pulse to the source layer |
| eoi_src | output | SRC_W | Source number being retired |
| resend_req | output | 1 | Request for the source layer to resend held-back interrupts |

## Verification
The hardest situations to reach are the chained paths, where one command sets off the resend procedure and that procedure fires the IPI check, so that a pending IPI and a resend pulse come out of a single command. The bench gets there by first writing an IPI priority while the current priority is still 0 (most favored), which stores the value but raises nothing, and then opening the current priority to 0xFF. A device source is also latched ahead of an IPI write, so the blocked check and the displacing check can both be seen through polls.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

  typedef enum logic [2:0] {
    OP_SET_CPPR = 3'd0,
    OP_SET_IPI  = 3'd1,
    OP_ACCEPT   = 3'd2,
    OP_EOI      = 3'd3,
    OP_POLL     = 3'd4
  } ipr_op_e;

  localparam int OP_W = 3;

endpackage

// File: rtl/ipr_cmd_stage.sv
// First evaluation step: applies an offer or a processor command to the
// present state and flags whether the IPI check must follow.
module ipr_cmd_stage
  import ipr_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              cmd_fire,
  input  ipr_op_e           cmd_op,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data,
  input  logic [PRIO_W-1:0] cur_cppr,
  input  logic [SRC_W-1:0]  cur_src,
  input  logic [PRIO_W-1:0] cur_pprio,
  input  logic [PRIO_W-1:0] cur_ipi,
  output logic [PRIO_W-1:0] nx_cppr,
  output logic [SRC_W-1:0]  nx_src,
  output logic [PRIO_W-1:0] nx_pprio,
  output logic [PRIO_W-1:0] nx_ipi,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_id,
  output logic              eoi_v,
  output logic [SRC_W-1:0]  eoi_id,
  output logic              raise,
  output logic              lower,
  output logic              run_ipi_chk,
  output logic              run_resend
);

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  logic              busy;
  logic [PRIO_W-1:0] arg_prio;
  logic [PRIO_W-1:0] eoi_cppr;

  assign busy     = (cur_src != '0);
  assign arg_prio = cmd_data[PRIO_W-1:0];
  assign eoi_cppr = cmd_data[WORD_W-1 -: PRIO_W];

  always_comb begin
    nx_cppr     = cur_cppr;
    nx_src      = cur_src;
    nx_pprio    = cur_pprio;
    nx_ipi      = cur_ipi;
    rej_v       = 1'b0;
    rej_id      = '0;
    eoi_v       = 1'b0;
    eoi_id      = '0;
    raise       = 1'b0;
    lower       = 1'b0;
    run_ipi_chk = 1'b0;
    run_resend  = 1'b0;

    if (offer_valid) begin
      if ((offer_prio >= cur_cppr) || (busy && (cur_pprio <= offer_prio))) begin
        rej_v  = 1'b1;
        rej_id = offer_src;
      end else begin
        if (busy) begin
          rej_v  = 1'b1;
          rej_id = cur_src;
        end
        nx_src   = offer_src;
        nx_pprio = offer_prio;
        raise    = 1'b1;
      end
    end else if (cmd_fire) begin
      unique case (cmd_op)
        OP_SET_CPPR: begin
          nx_cppr = arg_prio;
          if (arg_prio < cur_cppr) begin
            if (busy && (arg_prio <= cur_pprio)) begin
              nx_src   = '0;
              nx_pprio = PRIO_NONE;
              lower    = 1'b1;
              rej_v    = 1'b1;
              rej_id   = cur_src;
            end
          end else if (!busy) begin
            run_resend  = 1'b1;
            run_ipi_chk = (cur_ipi < arg_prio);
          end
        end
        OP_SET_IPI: begin
          nx_ipi      = arg_prio;
          run_ipi_chk = (arg_prio < cur_cppr);
        end
        OP_ACCEPT: begin
          nx_cppr  = cur_pprio;
          nx_src   = '0;
          nx_pprio = PRIO_NONE;
          lower    = 1'b1;
        end
        OP_EOI: begin
          nx_cppr = eoi_cppr;
          eoi_v   = 1'b1;
          eoi_id  = cmd_data[SRC_W-1:0];
          if (!busy) begin
            run_resend  = 1'b1;
            run_ipi_chk = (cur_ipi < eoi_cppr);
          end
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/ipr_ipi_stage.sv
// Second evaluation step: the IPI check, applied on top of the first step.
module ipr_ipi_stage #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic              en,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [PRIO_W-1:0] in_pprio,
  input  logic [PRIO_W-1:0] ipi_prio,
  output logic [SRC_W-1:0]  out_src,
  output logic [PRIO_W-1:0] out_pprio,
  output logic              rej_v,
  output logic [SRC_W-1:0]  rej_id,
  output logic              raise
);

  localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

  logic held;
  assign held = (in_src != '0) && (in_pprio <= ipi_prio);

  always_comb begin
    out_src   = in_src;
    out_pprio = in_pprio;
    rej_v     = 1'b0;
    rej_id    = '0;
    raise     = 1'b0;
    if (en && !held) begin
      if (in_src != '0) begin
        rej_v  = 1'b1;
        rej_id = in_src;
      end
      out_src   = IPI_ID;
      out_pprio = ipi_prio;
      raise     = 1'b1;
    end
  end

endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
  import ipr_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    offer_valid,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRIO_W-1:0]       offer_prio,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [2:0]              cmd_op,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data,
  output logic                    rsp_valid,
  output logic [PRIO_W+SRC_W-1:0] rsp_word,
  output logic [PRIO_W-1:0]       rsp_ipi,
  output logic                    irq_out,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req
);

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  // architectural state
  logic [PRIO_W-1:0] cppr_q;
  logic [SRC_W-1:0]  src_q;
  logic [PRIO_W-1:0] pprio_q;
  logic [PRIO_W-1:0] ipi_q;
  logic              irq_q;

  ipr_op_e op;
  logic    fire;

  assign op        = ipr_op_e'(cmd_op);
  assign cmd_ready = ~offer_valid;
  assign fire      = cmd_valid & cmd_ready;

  // first step
  logic [PRIO_W-1:0] a_cppr, a_pprio, a_ipi;
  logic [SRC_W-1:0]  a_src, a_rej_id, a_eoi_id;
  logic              a_rej, a_eoi, a_raise, a_lower, a_chk, a_resend;

  ipr_cmd_stage #(
    .PRIO_W (PRIO_W),
    .SRC_W  (SRC_W)
  ) u_cmd (
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .cmd_fire    (fire),
    .cmd_op      (op),
    .cmd_data    (cmd_data),
    .cur_cppr    (cppr_q),
    .cur_src     (src_q),
    .cur_pprio   (pprio_q),
    .cur_ipi     (ipi_q),
    .nx_cppr     (a_cppr),
    .nx_src      (a_src),
    .nx_pprio    (a_pprio),
    .nx_ipi      (a_ipi),
    .rej_v       (a_rej),
    .rej_id      (a_rej_id),
    .eoi_v       (a_eoi),
    .eoi_id      (a_eoi_id),
    .raise       (a_raise),
    .lower       (a_lower),
    .run_ipi_chk (a_chk),
    .run_resend  (a_resend)
  );

  // second step
  logic [SRC_W-1:0]  b_src, b_rej_id;
  logic [PRIO_W-1:0] b_pprio;
  logic              b_rej, b_raise;

  ipr_ipi_stage #(
    .PRIO_W  (PRIO_W),
    .SRC_W   (SRC_W),
    .IPI_SRC (IPI_SRC)
  ) u_ipi (
    .en        (a_chk),
    .in_src    (a_src),
    .in_pprio  (a_pprio),
    .ipi_prio  (a_ipi),
    .out_src   (b_src),
    .out_pprio (b_pprio),
    .rej_v     (b_rej),
    .rej_id    (b_rej_id),
    .raise     (b_raise)
  );

  logic take_rsp;
  assign take_rsp = fire && ((op == OP_ACCEPT) || (op == OP_POLL));

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q     <= '0;
      src_q      <= '0;
      pprio_q    <= PRIO_NONE;
      ipi_q      <= PRIO_NONE;
      irq_q      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_word   <= '0;
      rsp_ipi    <= PRIO_NONE;
      rej_valid  <= 1'b0;
      rej_src    <= '0;
      eoi_valid  <= 1'b0;
      eoi_src    <= '0;
      resend_req <= 1'b0;
    end else begin
      cppr_q  <= a_cppr;
      src_q   <= b_src;
      pprio_q <= b_pprio;
      ipi_q   <= a_ipi;
      if (a_raise || b_raise) begin
        irq_q <= 1'b1;
      end else if (a_lower) begin
        irq_q <= 1'b0;
      end
      rsp_valid <= take_rsp;
      if (take_rsp) begin
        rsp_word <= {cppr_q, src_q};
        rsp_ipi  <= ipi_q;
      end
      rej_valid  <= a_rej | b_rej;
      rej_src    <= a_rej ? a_rej_id : (b_rej ? b_rej_id : '0);
      eoi_valid  <= a_eoi;
      eoi_src    <= a_eoi_id;
      resend_req <= a_resend;
    end
  end

  assign irq_out = irq_q;

endmodule

// File: rtl/ipr_checker.sv
module ipr_checker #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              offer_valid,
  input logic [PRIO_W-1:0] offer_prio,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              irq_out,
  input logic              rsp_valid,
  input logic              rej_valid,
  input logic [SRC_W-1:0]  rej_src,
  input logic [PRIO_W-1:0] cppr,
  input logic [SRC_W-1:0]  pend_src,
  input logic [PRIO_W-1:0] pend_prio
);

  logic fire;
  assign fire = cmd_valid && cmd_ready;

  AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_out == (pend_src != '0)); // R4

  AST_IDLE_PRIO_NONE: assert property (@(posedge clk) disable iff (rst)
    (pend_src == '0) |-> (pend_prio == '1)); // R5

  AST_REJECT_NAMES_SOURCE: assert property (@(posedge clk) disable iff (rst)
    rej_valid |-> (rej_src != '0)); // R2

  AST_OFFER_BLOCKS_CMD: assert property (@(posedge clk) disable iff (rst)
    offer_valid |-> !cmd_ready); // R12

  AST_ACCEPT_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (fire && cmd_op == 3'd2) |=> (!irq_out && rsp_valid)); // R5

  AST_POLL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (fire && cmd_op == 3'd4) |=> (rsp_valid && $stable(irq_out) && $stable(pend_src))); // R11

  AST_LOW_OFFER_REJECTED: assert property (@(posedge clk) disable iff (rst)
    (offer_valid && offer_prio >= cppr) |=> (rej_valid && $stable(pend_src))); // R2

  AST_OFFER_TAKES: assert property (@(posedge clk) disable iff (rst)
    (offer_valid && offer_prio < cppr && (pend_src == '0 || offer_prio < pend_prio))
      |=> (irq_out && pend_prio == $past(offer_prio))); // R4

endmodule

bind cpu_irq_presenter ipr_checker #(
  .PRIO_W (PRIO_W),
  .SRC_W  (SRC_W)
) u_ipr_checker (
  .clk         (clk),
  .rst         (rst),
  .offer_valid (offer_valid),
  .offer_prio  (offer_prio),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_op      (cmd_op),
  .irq_out     (irq_out),
  .rsp_valid   (rsp_valid),
  .rej_valid   (rej_valid),
  .rej_src     (rej_src),
  .cppr        (cppr_q),
  .pend_src    (src_q),
  .pend_prio   (pprio_q)
);

// File: tb/test_cpu_irq_presenter.sv
module test_cpu_irq_presenter;

  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;

  localparam logic [2:0] C_CPPR = 3'd0, C_IPI = 3'd1, C_ACC = 3'd2, C_EOI = 3'd3, C_POLL = 3'd4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              offer_valid = 1'b0;
  logic [SRC_W-1:0]  offer_src = '0;
  logic [PRIO_W-1:0] offer_prio = '0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [2:0]        cmd_op = '0;
  logic [WORD_W-1:0] cmd_data = '0;
  logic              rsp_valid;
  logic [WORD_W-1:0] rsp_word;
  logic [PRIO_W-1:0] rsp_ipi;
  logic              irq_out;
  logic              rej_valid;
  logic [SRC_W-1:0]  rej_src;
  logic              eoi_valid;
  logic [SRC_W-1:0]  eoi_src;
  logic              resend_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu_irq_presenter #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(2)) i_cpu_irq_presenter (
    .clk, .rst, .offer_valid, .offer_src, .offer_prio, .cmd_valid, .cmd_ready,
    .cmd_op, .cmd_data, .rsp_valid, .rsp_word, .rsp_ipi, .irq_out,
    .rej_valid, .rej_src, .eoi_valid, .eoi_src, .resend_req
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive at a falling edge; results of the next rising edge are visible on return
  task automatic do_cmd(logic [2:0] op, logic [WORD_W-1:0] data);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = '0;
  endtask

  task automatic do_offer(logic [SRC_W-1:0] s, logic [PRIO_W-1:0] p);
    offer_valid = 1'b1;
    offer_src   = s;
    offer_prio  = p;
    @(negedge clk);
    offer_valid = 1'b0;
  endtask

  task automatic poll_chk(string req, logic [31:0] w, logic [7:0] ipi);
    do_cmd(C_POLL, '0);
    chk({req, " poll valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " poll word"}, rsp_word, w);
    chk({req, " poll ipi"}, 32'(rsp_ipi), 32'(ipi));
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 rej", 32'(rej_valid), 0);
    chk("R1 resend", 32'(resend_req), 0);
    poll_chk("R1", 32'h0000_0000, 8'hFF);
    @(negedge clk);
    chk("R12 rsp one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic t_open_and_low_offers();
    do_reset();
    do_cmd(C_CPPR, 32'h80);
    chk("R7 no reject when idle", 32'(rej_valid), 0);
    do_offer(24'h10, 8'h80);
    chk("R2 equal rej", 32'(rej_valid), 1);
    chk("R2 equal rej src", 32'(rej_src), 32'h10);
    chk("R2 irq stays low", 32'(irq_out), 0);
    do_offer(24'h11, 8'h90);
    chk("R2 worse rej src", 32'(rej_src), 32'h11);
    poll_chk("R2 state kept", 32'h8000_0000, 8'hFF);
    do_cmd(C_CPPR, 32'hFF);
    chk("R8 resend pulse", 32'(resend_req), 1);
    chk("R8 no ipi", 32'(irq_out), 0);
  endtask

  task automatic t_preempt_accept_eoi();
    do_reset();
    do_cmd(C_CPPR, 32'hFF);
    do_offer(24'h5, 8'h40);
    chk("R4 taken no rej", 32'(rej_valid), 0);
    chk("R4 irq high", 32'(irq_out), 1);
    do_offer(24'h6, 8'h40);
    chk("R3 tie rej", 32'(rej_valid), 1);
    chk("R3 tie rej src", 32'(rej_src), 32'h6);
    do_offer(24'h7, 8'h20);
    chk("R4 displaced rej", 32'(rej_src), 32'h5);
    chk("R4 irq kept", 32'(irq_out), 1);
    poll_chk("R4", 32'hFF00_0007, 8'hFF);
    do_cmd(C_ACC, '0);
    chk("R5 rsp valid", 32'(rsp_valid), 1);
    chk("R5 word", rsp_word, 32'hFF00_0007);
    chk("R5 irq low", 32'(irq_out), 0);
    poll_chk("R5 after", 32'h2000_0000, 8'hFF);
    do_cmd(C_EOI, 32'hFF00_0007);
    chk("R6 eoi pulse", 32'(eoi_valid), 1);
    chk("R6 eoi src", 32'(eoi_src), 32'h7);
    chk("R6 resend", 32'(resend_req), 1);
    poll_chk("R6 cppr", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic t_cppr_tighten();
    do_reset();
    do_cmd(C_CPPR, 32'hFF);
    do_offer(24'h9, 8'h50);
    do_cmd(C_CPPR, 32'h60);
    chk("R7 favored kept no rej", 32'(rej_valid), 0);
    chk("R7 favored kept irq", 32'(irq_out), 1);
    do_cmd(C_CPPR, 32'h50);
    chk("R7 clear rej", 32'(rej_valid), 1);
    chk("R7 clear rej src", 32'(rej_src), 32'h9);
    chk("R7 irq low", 32'(irq_out), 0);
    poll_chk("R7", 32'h5000_0000, 8'hFF);
  endtask

  task automatic t_ipi();
    do_reset();
    do_cmd(C_CPPR, 32'hFF);
    do_cmd(C_IPI, 32'h30);
    chk("R9 irq", 32'(irq_out), 1);
    chk("R9 no rej", 32'(rej_valid), 0);
    poll_chk("R9", 32'hFF00_0002, 8'h30);
    do_offer(24'h4, 8'h30);
    chk("R3 vs ipi rej src", 32'(rej_src), 32'h4);
    do_reset();
    do_cmd(C_CPPR, 32'hFF);
    do_offer(24'h8, 8'h10);
    do_cmd(C_IPI, 32'h10);
    chk("R10 no rej", 32'(rej_valid), 0);
    poll_chk("R10", 32'hFF00_0008, 8'h10);
    do_cmd(C_IPI, 32'h05);
    chk("R9 displace rej src", 32'(rej_src), 32'h8);
    poll_chk("R9 displaced", 32'hFF00_0002, 8'h05);
  endtask

  task automatic t_resend_fires_ipi();
    do_reset();
    do_cmd(C_IPI, 32'h40);
    chk("R9 held by cppr0 irq", 32'(irq_out), 0);
    poll_chk("R9 stored", 32'h0000_0000, 8'h40);
    do_cmd(C_CPPR, 32'hFF);
    chk("R8 resend pulse", 32'(resend_req), 1);
    chk("R8 ipi raised", 32'(irq_out), 1);
    poll_chk("R8", 32'hFF00_0002, 8'h40);
  endtask

  task automatic t_handshake();
    do_reset();
    do_cmd(C_CPPR, 32'hFF);
    offer_valid = 1'b1;
    offer_src   = 24'h3;
    offer_prio  = 8'h10;
    cmd_valid   = 1'b1;
    cmd_op      = C_POLL;
    #1;
    chk("R12 ready low", 32'(cmd_ready), 0);
    @(negedge clk);
    offer_valid = 1'b0;
    #1;
    chk("R12 ready back", 32'(cmd_ready), 1);
    chk("R12 stalled no rsp", 32'(rsp_valid), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12 rsp after take", 32'(rsp_valid), 1);
    chk("R12 rsp word", rsp_word, 32'hFF00_0003);
    @(negedge clk);
    chk("R12 rsp drops", 32'(rsp_valid), 0);
  endtask

  initial begin
    t_reset_state();
    t_open_and_low_offers();
    t_preempt_accept_eoi();
    t_cppr_tighten();
    t_ipi();
    t_resend_fires_ipi();
    t_handshake();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule